// File: doc/BRIEF.md
# CAM Configuration Register with Dual Register Sets

This block holds the 16-bit configuration word of a content-addressable memory device. It keeps one copy of the word per register set: a foreground copy and a background copy. A select input chooses the active copy, and every write, read and decoded field comes from that copy alone. Bit 15 of a written word is a command bit. When it is set, the write stores the lower fifteen bits and asks the array for an automatic compare. When it is clear, the write is a software reset: the data is discarded, every copy returns to its reset value, and a one-cycle reset pulse goes out to the rest of the device.

The block decodes the active word into the controls that the surrounding device needs. These are the operating mode, the address step after an access, the compare mask choice, the bit-reordering translation for 64-bit writes, and the CAM/RAM split of each word. It also drives the two flag-enable controls. A disabled match flag or full flag takes the device out of the cascade for that flag: the upstream flag passes straight through, and the instructions that depend on that flag are blocked.

Top module: `cam_cfg_reg`

## Requirements
- R1: A write with `wr_data[15]`=1 stores `{0, wr_data[14:0]}` into the copy chosen by `bank_sel` (0 = foreground, 1 = background). The other copy stays unchanged.
- R2: A write with `wr_data[15]`=0 stores no data. At that clock edge every copy loads 0x0008, and `soft_rst` is high for exactly the one cycle after that edge.
- R3: `cmp_start` is high for exactly the one cycle after the edge of a write with bit 15 set. It stays low after reset writes and when no write is made.
- R4: A read registers `{status_hi, active word}` onto `rd_data` at the clock edge. Bit 15 of `rd_data` is always 0, and `rd_data` holds its value when no read is made.
- R5: After `rst` both copies hold 0x0008. This gives standard mode, the address held, no mask, no translation, 64 CAM bits with the RAM at the low end, and both flags enabled.
- R6: Operating mode, bits 1:0: 01 sets `enh_mode`=1 (enhanced). Any other value gives standard mode.
- R7: Address step, bits 3:2: 00 gives `addr_step`=00 (increment), 01 gives 01 (decrement), and 10 or 11 give 10 (hold).
- R8: Mask select, bits 5:4: 01 gives `mask_sel`=01 (mask 1), 10 gives 10 (mask 2), and 00 or 11 give 00 (no mask).
- R9: Partition, bits 8:6: `cam_segs` = 3 − bits[7:6] is the number of 16-bit CAM segments minus one, and `ram_at_msb` = bit 8.
- R10: Translation, bits 10:9: 10 sets `xlate_en`=1. Any other value clears it.
- R11: Match-flag enable, bits 14:13: the value 10 disables the flag, and any other value enables it. When it is enabled: `hpm_ops_en`=1, `match_out` = `match_in | match_int` and `match_eff` = `match_int`. When it is disabled: `hpm_ops_en`=0, `match_out` = `match_in` and `match_eff`=0. Both outputs are registered one cycle after their inputs.
- R12: Full-flag enable, bits 12:11: the value 10 disables the flag, and any other value enables it. When it is enabled: `nf_ops_en`=`page_wr_en`=1, `full_out` = `full_in & full_int` and `full_eff` = `full_int`. When it is disabled: `nf_ops_en`=`page_wr_en`=0, `full_out` = `full_in` and `full_eff`=1. Both outputs are registered one cycle after their inputs.
- R13: The decoded fields and the read data always follow the copy selected by `bank_sel` at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bank_sel | input | 1 | Active register set (0 foreground, 1 background) |
| wr_data | input | 16 | Write data; bit 15 = store (1) or reset (0) |
| status_hi | input | 16 | Upper half of the status register, returned on reads |
| match_int | input | 1 | True internal match condition |
| match_in | input | 1 | Upstream cascade match flag |
| full_int | input | 1 | True internal full condition |
| full_in | input | 1 | Upstream cascade full flag |
| rd_data | output | 32 | Registered read data |
| enh_mode | output | 1 | Enhanced operating mode |
| addr_step | output | 2 | 00 increment, 01 decrement, 10 hold |
| mask_sel | output | 2 | 00 none, 01 mask 1, 10 mask 2 |
| xlate_en | output | 1 | Bit-reorder translation enabled |
| cam_segs | output | 2 | CAM 16-bit segments minus one |
| ram_at_msb | output | 1 | RAM part is at the high end of the word |
| hpm_ops_en | output | 1 | Highest-priority-match operations allowed |
| nf_ops_en | output | 1 | Next-free operations allowed |
| page_wr_en | output | 1 | Page address register writes allowed |
| soft_rst | output | 1 | One-cycle software reset pulse |
| cmp_start | output | 1 | One-cycle automatic compare request |
| match_out | output | 1 | Gated cascade match flag |
| full_out | output | 1 | Gated cascade full flag |
| match_eff | output | 1 | Match condition seen by the cascade logic |
| full_eff | output | 1 | Full condition seen by instruction logic |

## Verification
Results come due at three different times after a stimulus.

- **Decoded fields:** these are combinational from the stored copy, so they are due one clock edge after a write. After a change of `bank_sel` they are due at once. The bench applies each write at a falling edge and checks the fields at the next falling edge.
- **Pulses, read data and gated flags:** `soft_rst`, `cmp_start`, `rd_data` and the four gated flags each pass through one register. They are sampled at the falling edge that follows the rising edge on which their cause was taken.
- **End of the pulses:** `soft_rst` and `cmp_start` are sampled once more a full cycle later, to confirm that each pulse has ended.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;
  localparam int CW      = 16;
  localparam int MODE_LO = 0;
  localparam int STEP_LO = 2;
  localparam int MASK_LO = 4;
  localparam int PART_LO = 6;
  localparam int XL_LO   = 9;
  localparam int FF_LO   = 11;
  localparam int MF_LO   = 13;
  localparam int CMD_BIT = CW - 1;
  localparam logic [CW-1:0] CFG_RST = 16'h0008;
  localparam logic [1:0] FLAG_OFF  = 2'b10;
  localparam logic [1:0] XLATE_ON  = 2'b10;
  localparam logic [1:0] MODE_ENH  = 2'b01;

  typedef enum logic [1:0] {
    STEP_INC  = 2'b00,
    STEP_DEC  = 2'b01,
    STEP_HOLD = 2'b10
  } step_e;

  typedef enum logic [1:0] {
    MSK_NONE = 2'b00,
    MSK_ONE  = 2'b01,
    MSK_TWO  = 2'b10
  } msk_e;

  typedef struct packed {
    logic       enh;
    step_e      step;
    msk_e       mask;
    logic       xlate;
    logic [1:0] cam_segs;
    logic       ram_hi;
    logic       mf_en;
    logic       ff_en;
  } cfg_t;
endpackage

// File: rtl/cfg_bank.sv
module cfg_bank
  import cam_cfg_pkg::*;
#(
  parameter int NBANK = 2,
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    active,
  output logic             soft_rst_q,
  output logic             cmp_q
);
  logic [CW-1:0] bank_q [NBANK];
  logic reset_cmd;
  logic store_cmd;

  assign reset_cmd = wr_en & ~wdata[CMD_BIT];
  assign store_cmd = wr_en &  wdata[CMD_BIT];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || reset_cmd)
        bank_q[b] <= CFG_RST;
      else if (store_cmd && sel == SEL_W'(b))
        bank_q[b] <= {1'b0, wdata[CMD_BIT-1:0]};
    end

    assert_other_bank_kept_R1: assert property (@(posedge clk) disable iff (rst)
      (store_cmd && sel != SEL_W'(b)) |=> $stable(bank_q[b]));
    assert_bank_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
      reset_cmd |=> (bank_q[b] == CFG_RST));
  end

  assign active = bank_q[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst_q <= 1'b0;
      cmp_q      <= 1'b0;
    end else begin
      soft_rst_q <= reset_cmd;
      cmp_q      <= store_cmd;
    end
  end

  assert_rst_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    soft_rst_q |=> !soft_rst_q);
  assert_cmp_after_store_R3: assert property (@(posedge clk) disable iff (rst)
    store_cmd |=> cmp_q);
  assert_no_cmp_with_reset_R3: assert property (@(posedge clk) disable iff (rst)
    !(soft_rst_q && cmp_q));
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cam_cfg_pkg::*;
(
  input  logic [CW-1:0] word,
  output cfg_t          cfg
);
  logic [1:0] mode_f, step_f, mask_f, xl_f, ff_f, mf_f;
  logic [2:0] part_f;

  assign mode_f = word[MODE_LO +: 2];
  assign step_f = word[STEP_LO +: 2];
  assign mask_f = word[MASK_LO +: 2];
  assign part_f = word[PART_LO +: 3];
  assign xl_f   = word[XL_LO   +: 2];
  assign ff_f   = word[FF_LO   +: 2];
  assign mf_f   = word[MF_LO   +: 2];

  always_comb begin
    cfg.enh = (mode_f == MODE_ENH);
    case (step_f)
      2'b00:   cfg.step = STEP_INC;
      2'b01:   cfg.step = STEP_DEC;
      default: cfg.step = STEP_HOLD;
    endcase
    case (mask_f)
      2'b01:   cfg.mask = MSK_ONE;
      2'b10:   cfg.mask = MSK_TWO;
      default: cfg.mask = MSK_NONE;
    endcase
    cfg.xlate    = (xl_f == XLATE_ON);
    cfg.cam_segs = 2'd3 - part_f[1:0];
    cfg.ram_hi   = part_f[2];
    cfg.mf_en    = (mf_f != FLAG_OFF);
    cfg.ff_en    = (ff_f != FLAG_OFF);
  end
endmodule

// File: rtl/flag_gate.sv
module flag_gate (
  input  logic clk,
  input  logic rst,
  input  logic mf_en,
  input  logic ff_en,
  input  logic match_int,
  input  logic match_in,
  input  logic full_int,
  input  logic full_in,
  output logic match_out,
  output logic full_out,
  output logic match_eff,
  output logic full_eff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      match_out <= 1'b0;
      full_out  <= 1'b0;
      match_eff <= 1'b0;
      full_eff  <= 1'b0;
    end else begin
      match_eff <= mf_en & match_int;
      match_out <= match_in | (mf_en & match_int);
      full_eff  <= ~ff_en | full_int;
      full_out  <= ff_en ? (full_in & full_int) : full_in;
    end
  end

  assert_match_bypass_R11: assert property (@(posedge clk) disable iff (rst)
    !mf_en |=> (match_out == $past(match_in)) && !match_eff);
  assert_match_upstream_R11: assert property (@(posedge clk) disable iff (rst)
    match_in |=> match_out);
  assert_full_bypass_R12: assert property (@(posedge clk) disable iff (rst)
    !ff_en |=> (full_out == $past(full_in)) && full_eff);
  assert_full_needs_upstream_R12: assert property (@(posedge clk) disable iff (rst)
    !full_in |=> !full_out);
endmodule

// File: rtl/cam_cfg_reg.sv
module cam_cfg_reg
  import cam_cfg_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              bank_sel,
  input  logic [15:0]       wr_data,
  input  logic [STAT_W-1:0] status_hi,
  input  logic              match_int,
  input  logic              match_in,
  input  logic              full_int,
  input  logic              full_in,
  output logic [STAT_W+15:0] rd_data,
  output logic              enh_mode,
  output logic [1:0]        addr_step,
  output logic [1:0]        mask_sel,
  output logic              xlate_en,
  output logic [1:0]        cam_segs,
  output logic              ram_at_msb,
  output logic              hpm_ops_en,
  output logic              nf_ops_en,
  output logic              page_wr_en,
  output logic              soft_rst,
  output logic              cmp_start,
  output logic              match_out,
  output logic              full_out,
  output logic              match_eff,
  output logic              full_eff
);
  logic [CW-1:0] active_w;
  cfg_t          cfg;

  cfg_bank #(.NBANK(2)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .sel        (bank_sel),
    .wdata      (wr_data),
    .active     (active_w),
    .soft_rst_q (soft_rst),
    .cmp_q      (cmp_start)
  );

  cfg_decode u_dec (
    .word (active_w),
    .cfg  (cfg)
  );

  flag_gate u_flags (
    .clk       (clk),
    .rst       (rst),
    .mf_en     (cfg.mf_en),
    .ff_en     (cfg.ff_en),
    .match_int (match_int),
    .match_in  (match_in),
    .full_int  (full_int),
    .full_in   (full_in),
    .match_out (match_out),
    .full_out  (full_out),
    .match_eff (match_eff),
    .full_eff  (full_eff)
  );

  assign enh_mode   = cfg.enh;
  assign addr_step  = cfg.step;
  assign mask_sel   = cfg.mask;
  assign xlate_en   = cfg.xlate;
  assign cam_segs   = cfg.cam_segs;
  assign ram_at_msb = cfg.ram_hi;
  assign hpm_ops_en = cfg.mf_en;
  assign nf_ops_en  = cfg.ff_en;
  assign page_wr_en = cfg.ff_en;

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= {status_hi, active_w};
  end

  assert_cmd_bit_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[15]);
  assert_read_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_status_passed_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[STAT_W+15:16] == $past(status_hi));
  assert_step_legal_R7: assert property (@(posedge clk) disable iff (rst)
    addr_step != 2'b11);
endmodule

// File: tb/test_cam_cfg_reg.sv
module test_cam_cfg_reg;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bank;
    logic [15:0] wd;
    logic [10:0] exp_f;
  } vec_t;

  // exp_f = {addr_step, mask_sel, enh, xlate, cam_segs, ram_hi, hpm_en, nf_en}
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h8008, {2'd2, 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1}},
    '{1'b0, 16'h8451, {2'd0, 2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1}},
    '{1'b1, 16'hC3E6, {2'd1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1}},
    '{1'b1, 16'hB7BF, {2'd2, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0}},
    '{1'b0, 16'hFFFF, {2'd2, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}},
    '{1'b0, 16'hD081, {2'd0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0}}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, bank_sel = 1'b0;
  logic [15:0] wr_data = '0, status_hi = '0;
  logic match_int = 1'b0, match_in = 1'b0, full_int = 1'b0, full_in = 1'b0;
  logic [31:0] rd_data;
  logic enh_mode, xlate_en, ram_at_msb, hpm_ops_en, nf_ops_en, page_wr_en;
  logic [1:0] addr_step, mask_sel, cam_segs;
  logic soft_rst, cmp_start, match_out, full_out, match_eff, full_eff;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_cfg_reg i_cam_cfg_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bank_sel(bank_sel),
    .wr_data(wr_data), .status_hi(status_hi), .match_int(match_int),
    .match_in(match_in), .full_int(full_int), .full_in(full_in),
    .rd_data(rd_data), .enh_mode(enh_mode), .addr_step(addr_step),
    .mask_sel(mask_sel), .xlate_en(xlate_en), .cam_segs(cam_segs),
    .ram_at_msb(ram_at_msb), .hpm_ops_en(hpm_ops_en), .nf_ops_en(nf_ops_en),
    .page_wr_en(page_wr_en), .soft_rst(soft_rst), .cmp_start(cmp_start),
    .match_out(match_out), .full_out(full_out), .match_eff(match_eff),
    .full_eff(full_eff)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] fields();
    return {addr_step, mask_sel, enh_mode, xlate_en, cam_segs, ram_at_msb,
            hpm_ops_en, nf_ops_en};
  endfunction

  // write at a falling edge; returns at the falling edge after the write edge
  task automatic do_write(input logic b, input logic [15:0] d);
    @(negedge clk);
    bank_sel = b; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic b, output logic [31:0] q);
    @(negedge clk);
    bank_sel = b; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    status_hi = 16'hA5C3;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5: reset state
    chk("R5 fields after reset", {21'd0, fields()}, {21'd0, 2'd2, 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1});
    chk("R5 pulses idle", {30'd0, soft_rst, cmp_start}, 32'd0);
    chk("R12 page write enabled at reset", {31'd0, page_wr_en}, 32'd1);
    do_read(1'b0, q);
    chk("R5 R4 foreground read after reset", q, 32'hA5C3_0008);
    do_read(1'b1, q);
    chk("R5 background read after reset", q, 32'hA5C3_0008);

    // table walk: R1 R3 R4 R6 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].bank, VECS[i].wd);
      chk($sformatf("R3 cmp pulse vec %0d", i), {31'd0, cmp_start}, 32'd1);
      chk($sformatf("R6-R12 fields vec %0d", i), {21'd0, fields()}, {21'd0, VECS[i].exp_f});
      @(negedge clk);
      chk($sformatf("R3 cmp ends vec %0d", i), {31'd0, cmp_start}, 32'd0);
      status_hi = 16'h1000 + 16'(i);
      do_read(VECS[i].bank, q);
      chk($sformatf("R1 R4 readback vec %0d", i), q,
          {16'h1000 + 16'(i), 1'b0, VECS[i].wd[14:0]});
    end

    // R13 / R1: copies kept apart
    bank_sel = 1'b1;
    #1;
    chk("R13 fields follow background", {21'd0, fields()}, {21'd0, VECS[3].exp_f});
    do_read(1'b1, q);
    chk("R1 background kept", q[15:0], 32'h37BF);
    do_read(1'b0, q);
    chk("R13 foreground read", q[15:0], 32'h5081);
    @(negedge clk);
    chk("R4 rd_data holds without read", q, rd_data);

    // R2: software reset via background write, data ignored
    do_write(1'b1, 16'h1234);
    chk("R2 soft reset pulse", {31'd0, soft_rst}, 32'd1);
    chk("R3 no compare on reset write", {31'd0, cmp_start}, 32'd0);
    @(negedge clk);
    chk("R2 pulse one cycle", {31'd0, soft_rst}, 32'd0);
    do_read(1'b0, q);
    chk("R2 foreground reset value", q[15:0], 32'h0008);
    do_read(1'b1, q);
    chk("R2 background reset value", q[15:0], 32'h0008);

    // R11 / R12 flags enabled (foreground 0x0008)
    @(negedge clk);
    bank_sel = 1'b0; match_int = 1'b1; match_in = 1'b0; full_int = 1'b1; full_in = 1'b0;
    @(negedge clk);
    chk("R11 enabled match_out", {31'd0, match_out}, 32'd1);
    chk("R11 enabled match_eff", {31'd0, match_eff}, 32'd1);
    chk("R12 enabled full_out needs upstream", {31'd0, full_out}, 32'd0);
    chk("R12 enabled full_eff", {31'd0, full_eff}, 32'd1);
    full_in = 1'b1; full_int = 1'b0;
    @(negedge clk);
    chk("R12 enabled not full", {30'd0, full_out, full_eff}, 32'd0);

    // flags disabled
    do_write(1'b0, 16'hD000);
    match_int = 1'b1; match_in = 1'b0; full_int = 1'b0; full_in = 1'b1;
    @(negedge clk);
    chk("R11 disabled match passes upstream", {30'd0, match_out, match_eff}, 32'd0);
    chk("R12 disabled full passes upstream", {30'd0, full_out, full_eff}, 32'd3);
    chk("R11 R12 ops blocked", {29'd0, hpm_ops_en, nf_ops_en, page_wr_en}, 32'd0);
    match_in = 1'b1; full_in = 1'b0;
    @(negedge clk);
    chk("R11 disabled upstream match", {31'd0, match_out}, 32'd1);
    chk("R12 disabled upstream not full", {31'd0, full_out}, 32'd0);

    // R5: hardware reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R5 fields after rst", {21'd0, fields()}, {21'd0, 2'd2, 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1});
    do_read(1'b0, q);
    chk("R5 value after rst", q[15:0], 32'h0008);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule